// File: doc/BRIEF.md
# Single-Block Surface Read Cache

This block sits between a pixel access engine and a byte-addressed backing memory. It holds one copy of a naturally aligned 4096-byte region of a surface. Reads of 1, 2 or 4 bytes that fall inside that region are answered from local storage one cycle after acceptance. A read that falls outside it first streams the whole region from memory as a burst of 32-bit words, lowest word first, and then answers.

Writes are never merged into the held copy. Each write goes straight to memory as one or two byte-enabled word beats, and the held copy is dropped. An explicit invalidate input also drops the copy. A pixel-format input selects plain handling or xRGB handling. In xRGB mode, full-word reads return an opaque alpha byte, and full-word writes leave the alpha byte in memory untouched.

Top module: `pix_block_cache`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, mem_rd_req and mem_wr_en are 0. After reset, and after any cycle with inval high, the next read starts a fill.
- R2: A read is a miss when no block is held or when its block base (the request address with bits 11:0 cleared) differs from the held base. A miss raises mem_rd_req for one cycle with mem_rd_addr equal to that base. It then takes 1024 beats on mem_rd_valid/mem_rd_data, where beat k supplies bytes base+4k to base+4k+3. req_ready stays 0 until the response has been delivered.
- R3: A read that hits starts no fill, and rsp_valid rises exactly one cycle after the request is accepted.
- R4: req_size 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. Read data is little-endian: byte address+j lands in bits 8j+7:8j, and unused upper bits are zero. Any byte offset inside the block is allowed, including accesses that span two adjacent words.
- R5: A write is forwarded as beats on mem_wr_en with a word address (bits 1:0 zero). Enable bit i selects lane bits 8i+7:8i. Value byte j goes to address+j. When the bytes span two words, the block issues two beats on consecutive cycles, lower word first.
- R6: Every accepted write, of any size, drops the held block, so the next read misses.
- R7: With xrgb_mode high, a 4-byte read returns bits 31:24 as 0xFF. 1- and 2-byte reads return the stored bytes unchanged.
- R8: With xrgb_mode high, a 4-byte write does not enable the byte at address+3. That memory byte keeps its old value.
- R9: If inval is high at any time during a fill, the pending read is still answered with the fetched data, but the block is not kept and the next read misses.
- R10: A write presented during a fill is not accepted until the response to the pending read has been delivered. The fetched block is then dropped by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write value, little-endian |
| xrgb_mode | input | 1 | Selects xRGB handling of full-word accesses |
| inval | input | 1 | Drops the held block |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| mem_rd_req | output | 1 | One-cycle burst read request |
| mem_rd_addr | output | ADDR_W | Burst base address |
| mem_rd_valid | input | 1 | Burst beat valid |
| mem_rd_data | input | 32 | Burst beat data |
| mem_wr_en | output | 1 | Write beat valid |
| mem_wr_addr | output | ADDR_W | Word address of write beat |
| mem_wr_be | output | 4 | Byte lane enables |
| mem_wr_data | output | 32 | Write beat data |

## Verification
The bench aims at word-spanning accesses. A 4-byte read at an odd offset, or a 2-byte write at offset 3, has to combine two words. A design that mishandles the second word returns wrong upper bytes or issues a single beat with bytes missing. Reads of the last word and half-word of a block are included, because a design that reads past the top word there returns garbage. An invalidate pulse in the middle of a fill and a write held back behind a fill are also exercised. If either of those left the block valid, the next read would hit and return stale data instead of starting a fill. The xRGB cases include misaligned full-word writes, so a design that masked lane 3 instead of the alpha byte's real lane would corrupt memory.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  localparam int WORD_BITS  = 32;
  localparam int WORD_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } fsm_e;

  // Lane pattern for an access of the given size code, starting at lane 0.
  function automatic logic [3:0] size_lanes(input logic [1:0] sz);
    logic [3:0] l;
    case (sz)
      2'd0:    l = 4'b0001;
      2'd1:    l = 4'b0011;
      default: l = 4'b1111;
    endcase
    return l;
  endfunction

  // Extract a little-endian value from a pair of adjacent words.
  function automatic logic [31:0] pick_bytes(input logic [31:0] lo,
                                             input logic [31:0] hi,
                                             input logic [1:0]  off,
                                             input logic [1:0]  sz,
                                             input logic        xrgb);
    logic [63:0] pair;
    logic [31:0] v;
    pair = {hi, lo} >> {off, 3'b000};
    v    = pair[31:0];
    case (sz)
      2'd0:    v = {24'd0, v[7:0]};
      2'd1:    v = {16'd0, v[15:0]};
      default: if (xrgb) v[31:24] = 8'hFF;
    endcase
    return v;
  endfunction

  // Byte enables over two adjacent words for a write.
  function automatic logic [7:0] lane_enables(input logic [1:0] off,
                                              input logic [1:0] sz,
                                              input logic       xrgb);
    logic [3:0] l;
    l = size_lanes(sz);
    if (sz[1] && xrgb) l = 4'b0111;
    return {4'd0, l} << off;
  endfunction

  // Write value placed over two adjacent words.
  function automatic logic [63:0] lane_data(input logic [31:0] wdata,
                                            input logic [1:0]  off);
    return {32'd0, wdata} << {off, 3'b000};
  endfunction

endpackage

// File: rtl/pbc_tag_ctrl.sv
module pbc_tag_ctrl #(
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop_i,
  input  logic             fill_start_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             fill_done_i,
  input  logic             fill_active_i,
  input  logic [TAG_W-1:0] probe_tag_i,
  output logic             hit_o,
  output logic             valid_o
);

  logic [TAG_W-1:0] tag_q;
  logic             valid_q;
  logic             discard_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q     <= '0;
      valid_q   <= 1'b0;
      discard_q <= 1'b0;
    end else if (fill_start_i) begin
      tag_q     <= fill_tag_i;
      valid_q   <= 1'b0;
      discard_q <= drop_i;
    end else if (fill_done_i) begin
      valid_q   <= !(discard_q || drop_i);
      discard_q <= 1'b0;
    end else begin
      if (drop_i) valid_q <= 1'b0;
      if (drop_i && fill_active_i) discard_q <= 1'b1;
    end
  end

  assign hit_o   = valid_q && (tag_q == probe_tag_i);
  assign valid_o = valid_q;

endmodule

// File: rtl/pbc_block_store.sv
module pbc_block_store #(
  parameter int WORDS = 1024,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_lo_o,
  output logic [31:0]      rd_hi_o
);

  logic [31:0]      words_q [WORDS];
  logic [IDX_W-1:0] hi_idx;

  always_ff @(posedge clk) begin
    if (wr_en_i) words_q[wr_idx_i] <= wr_data_i;
  end

  // The upper neighbour is clamped at the top word: accesses never leave the block.
  assign hi_idx  = (rd_idx_i == IDX_W'(WORDS - 1)) ? rd_idx_i : rd_idx_i + IDX_W'(1);
  assign rd_lo_o = words_q[rd_idx_i];
  assign rd_hi_o = words_q[hi_idx];

endmodule

// File: rtl/pbc_write_path.sv
module pbc_write_path
  import pbc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  input  logic              xrgb_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [3:0]        wr_be_o,
  output logic [31:0]       wr_data_o,
  output logic              busy_o
);

  logic [7:0]        lanes;
  logic [63:0]       spread;
  logic [ADDR_W-1:0] word_addr;

  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        be_q;
  logic [31:0]       data_q;
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [3:0]        pend_be_q;
  logic [31:0]       pend_data_q;

  assign lanes     = lane_enables(addr_i[1:0], size_i, xrgb_i);
  assign spread    = lane_data(wdata_i, addr_i[1:0]);
  assign word_addr = {addr_i[ADDR_W-1:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      addr_q      <= '0;
      be_q        <= '0;
      data_q      <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_be_q   <= '0;
      pend_data_q <= '0;
    end else if (start_i) begin
      en_q        <= 1'b1;
      addr_q      <= word_addr;
      be_q        <= lanes[3:0];
      data_q      <= spread[31:0];
      pend_q      <= |lanes[7:4];
      pend_addr_q <= word_addr + ADDR_W'(4);
      pend_be_q   <= lanes[7:4];
      pend_data_q <= spread[63:32];
    end else if (pend_q) begin
      en_q   <= 1'b1;
      addr_q <= pend_addr_q;
      be_q   <= pend_be_q;
      data_q <= pend_data_q;
      pend_q <= 1'b0;
    end else begin
      en_q <= 1'b0;
    end
  end

  assign wr_en_o   = en_q;
  assign wr_addr_o = addr_q;
  assign wr_be_o   = be_q;
  assign wr_data_o = data_q;
  assign busy_o    = pend_q;

endmodule

// File: rtl/pix_block_cache.sv
module pix_block_cache
  import pbc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic              xrgb_mode,
  input  logic              inval,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [3:0]        mem_wr_be,
  output logic [31:0]       mem_wr_data
);

  localparam int WORDS = BLOCK_BYTES / WORD_BYTES;
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = OFF_W - $clog2(WORD_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;

  fsm_e             state_q;
  logic [IDX_W-1:0] beat_q;
  logic [OFF_W-1:0] h_off_q;
  logic [1:0]       h_size_q;
  logic             h_xrgb_q;

  logic             accept;
  logic             hit;
  logic             line_valid;
  logic             wr_busy;
  logic             acc_read_hit;
  logic             acc_read_miss;
  logic             acc_write;
  logic             fill_busy;
  logic             fill_beat;
  logic             fill_last;
  logic             drop_line;
  logic [TAG_W-1:0] probe_tag;

  logic [OFF_W-1:0] rd_off;
  logic [1:0]       rd_size;
  logic             rd_xrgb;
  logic [31:0]      rd_lo;
  logic [31:0]      rd_hi;
  logic [31:0]      picked;

  // Named request events, shared with the checker.
  assign req_ready     = (state_q == ST_IDLE) && !wr_busy;
  assign accept        = req_valid && req_ready;
  assign probe_tag     = req_addr[ADDR_W-1:OFF_W];
  assign acc_read_hit  = accept && !req_write && hit;
  assign acc_read_miss = accept && !req_write && !hit;
  assign acc_write     = accept && req_write;
  assign fill_busy     = (state_q == ST_FILL);
  assign fill_beat     = fill_busy && mem_rd_valid;
  assign fill_last     = fill_beat && (beat_q == IDX_W'(WORDS - 1));
  assign drop_line     = inval || acc_write;

  pbc_tag_ctrl #(.TAG_W(TAG_W)) u_tag (
    .clk           (clk),
    .rst_n         (rst_n),
    .drop_i        (drop_line),
    .fill_start_i  (acc_read_miss),
    .fill_tag_i    (probe_tag),
    .fill_done_i   (fill_last),
    .fill_active_i (fill_busy),
    .probe_tag_i   (probe_tag),
    .hit_o         (hit),
    .valid_o       (line_valid)
  );

  // Read side: a hit looks at the live request, the post-fill answer at the held one.
  assign rd_off  = (state_q == ST_DONE) ? h_off_q  : req_addr[OFF_W-1:0];
  assign rd_size = (state_q == ST_DONE) ? h_size_q : req_size;
  assign rd_xrgb = (state_q == ST_DONE) ? h_xrgb_q : xrgb_mode;

  pbc_block_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .wr_en_i   (fill_beat),
    .wr_idx_i  (beat_q),
    .wr_data_i (mem_rd_data),
    .rd_idx_i  (rd_off[OFF_W-1:2]),
    .rd_lo_o   (rd_lo),
    .rd_hi_o   (rd_hi)
  );

  assign picked = pick_bytes(rd_lo, rd_hi, rd_off[1:0], rd_size, rd_xrgb);

  pbc_write_path #(.ADDR_W(ADDR_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (acc_write),
    .addr_i    (req_addr),
    .size_i    (req_size),
    .wdata_i   (req_wdata),
    .xrgb_i    (xrgb_mode),
    .wr_en_o   (mem_wr_en),
    .wr_addr_o (mem_wr_addr),
    .wr_be_o   (mem_wr_be),
    .wr_data_o (mem_wr_data),
    .busy_o    (wr_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      beat_q      <= '0;
      h_off_q     <= '0;
      h_size_q    <= '0;
      h_xrgb_q    <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      mem_rd_req <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (acc_read_hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= picked;
          end else if (acc_read_miss) begin
            state_q     <= ST_FILL;
            beat_q      <= '0;
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= {probe_tag, {OFF_W{1'b0}}};
            h_off_q     <= req_addr[OFF_W-1:0];
            h_size_q    <= req_size;
            h_xrgb_q    <= xrgb_mode;
          end
        end
        ST_FILL: begin
          if (fill_beat) begin
            beat_q <= beat_q + IDX_W'(1);
            if (fill_last) state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          rsp_valid <= 1'b1;
          rsp_data  <= picked;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pix_block_cache_chk.sv
module pix_block_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              xrgb_mode,
  input logic              inval,
  input logic              rsp_valid,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_en,
  input logic [3:0]        mem_wr_be,
  input logic              acc_read_hit,
  input logic              acc_read_miss,
  input logic              acc_write,
  input logic              fill_busy,
  input logic              line_valid
);

  assert_fill_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[OFF_W-1:0] == '0));

  assert_miss_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_read_miss |=> (mem_rd_req && !rsp_valid));

  assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_read_hit |=> (rsp_valid && !mem_rd_req));

  assert_write_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_write |=> !line_valid);

  assert_inval_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !line_valid);

  assert_fill_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !req_ready);

  assert_alpha_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_write && xrgb_mode && req_size[1] && (req_addr[1:0] == 2'b00))
      |=> (mem_wr_en && (mem_wr_be == 4'b0111)));

endmodule

bind pix_block_cache pix_block_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .req_size      (req_size),
  .xrgb_mode     (xrgb_mode),
  .inval         (inval),
  .rsp_valid     (rsp_valid),
  .mem_rd_req    (mem_rd_req),
  .mem_rd_addr   (mem_rd_addr),
  .mem_wr_en     (mem_wr_en),
  .mem_wr_be     (mem_wr_be),
  .acc_read_hit  (acc_read_hit),
  .acc_read_miss (acc_read_miss),
  .acc_write     (acc_write),
  .fill_busy     (fill_busy),
  .line_valid    (line_valid)
);

// File: tb/test_pix_block_cache.sv
module test_pix_block_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        xrgb_mode = 1'b0;
  logic        inval = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        mem_wr_en;
  logic [31:0] mem_wr_addr;
  logic [3:0]  mem_wr_be;
  logic [31:0] mem_wr_data;

  always #10 clk = ~clk;

  pix_block_cache i_pix_block_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .xrgb_mode(xrgb_mode), .inval(inval),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_be(mem_wr_be), .mem_wr_data(mem_wr_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int fills   = 0;
  int last_rsp_cyc = 0;
  int wr_acc_cyc = 0;
  int wr_wait = 0;
  bit done = 1'b0;
  logic [31:0] last_fill_addr = '0;

  logic [7:0] wmem [int unsigned];

  typedef struct { logic [31:0] data; bit hit; int acc; } rd_item_t;
  typedef struct { logic [31:0] addr; logic [3:0] be; logic [31:0] data; } wr_item_t;
  rd_item_t rd_q[$];
  string    rd_tag_q[$];
  wr_item_t wr_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(input logic [31:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd7;
    return m ^ a[15:8] ^ a[19:12] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    if (wmem.exists(int'(a))) return wmem[int'(a)];
    return pat(a);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Backing memory: answers each burst request with 1024 in-order beats, with gaps.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        logic [31:0] base;
        base = mem_rd_addr;
        last_fill_addr = base;
        fills++;
        for (int b = 0; b < 1024; b++) begin
          if (b % 7 == 3) begin
            mem_rd_valid = 1'b0;
            @(negedge clk);
          end
          mem_rd_valid = 1'b1;
          for (int j = 0; j < 4; j++)
            mem_rd_data[j*8 +: 8] = mbyte(base + 32'(4*b + j));
          @(negedge clk);
        end
        mem_rd_valid = 1'b0;
      end
    end
  end

  // Monitor: read responses
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      last_rsp_cyc = cyc;
      if (rd_q.size() == 0) begin
        check(1'b0, "R3", "unexpected response", rsp_data, 32'h0);
      end else begin
        rd_item_t it;
        string    tg;
        it = rd_q.pop_front();
        tg = rd_tag_q.pop_front();
        check(rsp_data == it.data, tg, "read data", rsp_data, it.data);
        if (it.hit)
          check(cyc == it.acc + 1, "R3", "hit latency", 32'(cyc - it.acc), 32'd1);
      end
    end
  end

  // Monitor: write beats
  always @(negedge clk) begin
    if (rst_n && mem_wr_en) begin
      if (wr_q.size() == 0) begin
        check(1'b0, "R5", "unexpected write beat", mem_wr_addr, 32'h0);
      end else begin
        wr_item_t w;
        logic [31:0] m;
        w = wr_q.pop_front();
        for (int j = 0; j < 4; j++) m[j*8 +: 8] = {8{w.be[j]}};
        check(mem_wr_addr == w.addr, "R5", "write address", mem_wr_addr, w.addr);
        check(mem_wr_be == w.be, "R8", "write enables", {28'd0, mem_wr_be}, {28'd0, w.be});
        check((mem_wr_data & m) == w.data, "R5", "write data", mem_wr_data & m, w.data);
      end
    end
  end

  task automatic do_read(input logic [31:0] a, input logic [1:0] sz, input bit x,
                         input bit exp_hit, input string tg);
    rd_item_t it;
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    it.data = '0;
    for (int i = 0; i < n; i++) it.data[i*8 +: 8] = mbyte(a + 32'(i));
    if (x && n == 4) it.data[31:24] = 8'hFF;
    it.hit = exp_hit;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz; xrgb_mode = x;
    while (!req_ready) @(negedge clk);
    it.acc = cyc;
    rd_q.push_back(it);
    rd_tag_q.push_back(tg);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input bit x);
    int n, wi, ln;
    logic [3:0]  be [2];
    logic [31:0] dd [2];
    wr_item_t w;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    be[0] = '0; be[1] = '0; dd[0] = '0; dd[1] = '0;
    for (int i = 0; i < n; i++) begin
      if (!(x && n == 4 && i == 3)) begin
        wi = (int'(a[1:0]) + i) / 4;
        ln = (int'(a[1:0]) + i) % 4;
        be[wi][ln] = 1'b1;
        dd[wi][ln*8 +: 8] = d[i*8 +: 8];
      end
    end
    w.addr = {a[31:2], 2'b00}; w.be = be[0]; w.data = dd[0];
    wr_q.push_back(w);
    if (be[1] != 4'd0) begin
      w.addr = {a[31:2], 2'b00} + 32'd4; w.be = be[1]; w.data = dd[1];
      wr_q.push_back(w);
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz;
    req_wdata = d; xrgb_mode = x;
    wr_wait = 0;
    while (!req_ready) begin
      wr_wait++;
      @(negedge clk);
    end
    wr_acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    for (int i = 0; i < n; i++)
      if (!(x && n == 4 && i == 3)) wmem[int'(a + 32'(i))] = d[i*8 +: 8];
  endtask

  task automatic drain();
    while (rd_q.size() != 0 || wr_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_inval();
    @(negedge clk);
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1", "ready after reset", {31'd0, req_ready}, 32'd1);
    check(rsp_valid == 1'b0, "R1", "rsp after reset", {31'd0, rsp_valid}, 32'd0);
    check(mem_rd_req == 1'b0 && mem_wr_en == 1'b0, "R1", "memory idle",
          {30'd0, mem_rd_req, mem_wr_en}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: first read misses and fetches the aligned block
    f0 = fills;
    do_read(32'h0001_2344, 2'd2, 1'b0, 1'b0, "R4");
    drain();
    check(fills == f0 + 1, "R2", "fill count", 32'(fills), 32'(f0 + 1));
    check(last_fill_addr == 32'h0001_2000, "R2", "fill base", last_fill_addr, 32'h0001_2000);

    // R3, R4: hits of each size, misaligned spans, top of block
    f0 = fills;
    do_read(32'h0001_2345, 2'd0, 1'b0, 1'b1, "R4");
    do_read(32'h0001_2346, 2'd1, 1'b0, 1'b1, "R4");
    do_read(32'h0001_2349, 2'd2, 1'b0, 1'b1, "R4");
    do_read(32'h0001_2337, 2'd1, 1'b0, 1'b1, "R4");
    do_read(32'h0001_2FFC, 2'd3, 1'b0, 1'b1, "R4");
    do_read(32'h0001_2FFE, 2'd1, 1'b0, 1'b1, "R4");
    // R7: alpha forced on full-word reads only
    do_read(32'h0001_2100, 2'd2, 1'b1, 1'b1, "R7");
    do_read(32'h0001_2103, 2'd0, 1'b1, 1'b1, "R7");
    do_read(32'h0001_2102, 2'd1, 1'b1, 1'b1, "R7");
    drain();
    check(fills == f0, "R3", "no fill on hits", 32'(fills), 32'(f0));

    // R2: other block, then back
    f0 = fills;
    do_read(32'h0002_0010, 2'd2, 1'b0, 1'b0, "R2");
    do_read(32'h0001_2000, 2'd2, 1'b0, 1'b0, "R2");
    drain();
    check(fills == f0 + 2, "R2", "fills on block change", 32'(fills), 32'(f0 + 2));

    // R1: invalidate forces a miss
    f0 = fills;
    pulse_inval();
    do_read(32'h0001_2004, 2'd2, 1'b0, 1'b0, "R1");
    drain();
    check(fills == f0 + 1, "R1", "miss after inval", 32'(fills), 32'(f0 + 1));

    // R5, R6: writes go to memory and drop the block
    f0 = fills;
    do_write(32'h0001_2010, 2'd2, 32'hDEAD_BEEF, 1'b0);
    do_read(32'h0001_2010, 2'd2, 1'b0, 1'b0, "R6");
    drain();
    check(fills == f0 + 1, "R6", "miss after write", 32'(fills), 32'(f0 + 1));
    f0 = fills;
    do_write(32'h0001_2023, 2'd1, 32'h0000_A1B2, 1'b0);
    do_write(32'h0001_2031, 2'd0, 32'h0000_0077, 1'b0);
    do_write(32'h0001_2035, 2'd2, 32'h1357_9BDF, 1'b0);
    do_read(32'h0001_2022, 2'd2, 1'b0, 1'b0, "R5");
    do_read(32'h0001_2030, 2'd2, 1'b0, 1'b1, "R5");
    do_read(32'h0001_2035, 2'd2, 1'b0, 1'b1, "R5");
    drain();
    check(fills == f0 + 1, "R6", "single refill after writes", 32'(fills), 32'(f0 + 1));

    // R8: xRGB writes keep the alpha byte
    do_write(32'h0001_2040, 2'd2, 32'h11223344, 1'b1);
    do_write(32'h0001_2051, 2'd2, 32'h55667788, 1'b1);
    do_write(32'h0001_2063, 2'd2, 32'h99AABBCC, 1'b1);
    do_read(32'h0001_2040, 2'd2, 1'b0, 1'b0, "R8");
    do_read(32'h0001_2051, 2'd2, 1'b0, 1'b1, "R8");
    do_read(32'h0001_2063, 2'd2, 1'b0, 1'b1, "R8");
    drain();

    // R9: invalidate during a fill
    f0 = fills;
    do_read(32'h0003_0008, 2'd2, 1'b0, 1'b0, "R9");
    repeat (300) @(negedge clk);
    pulse_inval();
    drain();
    do_read(32'h0003_000C, 2'd2, 1'b0, 1'b0, "R9");
    drain();
    check(fills == f0 + 2, "R9", "block not kept", 32'(fills), 32'(f0 + 2));

    // R10: write held behind a fill
    f0 = fills;
    do_read(32'h0004_0000, 2'd2, 1'b0, 1'b0, "R10");
    do_write(32'h0004_0008, 2'd2, 32'hCAFE_F00D, 1'b0);
    drain();
    check(wr_wait > 1000, "R10", "write waited for fill", 32'(wr_wait), 32'd1001);
    check(wr_acc_cyc >= last_rsp_cyc, "R10", "write after response",
          32'(wr_acc_cyc), 32'(last_rsp_cyc));
    do_read(32'h0004_0008, 2'd2, 1'b0, 1'b0, "R10");
    drain();
    check(fills == f0 + 2, "R10", "fetched block dropped", 32'(fills), 32'(f0 + 2));

    check(rd_q.size() == 0 && wr_q.size() == 0, "R3", "queues empty",
          32'(rd_q.size() + wr_q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule